// File: doc/BRIEF.md
# Cascadable Magnitude Comparator

This block compares two unsigned operands and raises exactly one of three flags: A below B, A equal to B, or A above B. It is built from identical 4-bit stages. Each stage has three cascade inputs that carry the verdict of the less significant part of the word. A stage acts on that verdict only when its own 4-bit fields tie. Stages chain to any width in this way.

The top module wires three stages into a 12-bit compare. The least significant stage is fed a constant "equal" verdict, and the most significant stage drives the three result flags. The logic is purely combinational: it holds no state and has no clock.

Top module: `mag_cmp_chain`

## Requirements
- R1: `gt_o` is 1 exactly when `a_i` is larger than `b_i` as 12-bit unsigned numbers.
- R2: `eq_o` is 1 exactly when `a_i` and `b_i` are identical. The lowest stage is seeded with lt=0, eq=1, gt=0, so equal operands yield eq only.
- R3: `lt_o` is 1 exactly when `a_i` is smaller than `b_i` as 12-bit unsigned numbers.
- R4: For every input, exactly one of `lt_o`, `eq_o`, `gt_o` is 1.
- R5: When the fields in bits 11..8 differ, they alone set the result, whatever bits 7..0 hold. Likewise, when bits 11..8 tie, bits 7..4 decide the result whenever they differ.
- R6: In a single stage whose two 4-bit fields differ, the outputs follow the local comparison, and the cascade inputs have no effect on them.
- R7: In a single stage whose two 4-bit fields are equal, each output copies its own cascade input (lt to lt, eq to eq, gt to gt). This also holds for combinations that are not one-hot, such as all zeros or all ones.
- R8: Inside a stage, the most significant differing bit pair sets the result. For example, 4'b1000 against 4'b0111 gives greater.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 12 | First unsigned operand |
| b_i | input | 12 | Second unsigned operand |
| lt_o | output | 1 | a_i is smaller than b_i |
| eq_o | output | 1 | a_i equals b_i |
| gt_o | output | 1 | a_i is larger than b_i |

## Verification
The chained result is tried on random operand pairs, which almost always differ in the top field. It is also tried on pairs that are equal or differ in a single bit, and on pairs that tie in the upper fields but differ below; only these exercise the cascade path between stages. Extreme values such as all zeros and all ones check the limits of the unsigned range. A standalone stage is driven with every cascade combination, first with equal fields and then with unequal fields, to separate pass-through from local override.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;

  // verdict carried between bit cells and between stages
  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
  } verdict_t;

  localparam verdict_t VERDICT_EQ = '{lt: 1'b0, eq: 1'b1, gt: 1'b0};

endpackage

// File: rtl/mag_cmp_bit.sv
module mag_cmp_bit
  import mag_cmp_pkg::*;
(
  input  logic     a_i,
  input  logic     b_i,
  input  verdict_t low_i,
  output verdict_t res_o
);

  logic differ;

  assign differ = a_i ^ b_i;

  always_comb begin
    if (differ) begin
      res_o.gt = a_i;
      res_o.lt = b_i;
      res_o.eq = 1'b0;
    end else begin
      res_o = low_i;
    end
  end

endmodule

// File: rtl/mag_cmp_stage.sv
module mag_cmp_stage
  import mag_cmp_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             lt_i,
  input  logic             eq_i,
  input  logic             gt_i,
  output logic             lt_o,
  output logic             eq_o,
  output logic             gt_o
);

  // link[k] is the verdict after bit k-1; the LSB cell sees the cascade
  verdict_t link [WIDTH+1];

  assign link[0] = '{lt: lt_i, eq: eq_i, gt: gt_i};

  for (genvar k = 0; k < WIDTH; k++) begin : g_bit
    mag_cmp_bit u_bit (
      .a_i   (a_i[k]),
      .b_i   (b_i[k]),
      .low_i (link[k]),
      .res_o (link[k+1])
    );
  end

  assign lt_o = link[WIDTH].lt;
  assign eq_o = link[WIDTH].eq;
  assign gt_o = link[WIDTH].gt;

endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
  import mag_cmp_pkg::*;
#(
  parameter int unsigned SLICE_W    = 4,
  parameter int unsigned NUM_SLICES = 3,
  localparam int unsigned DATA_W    = SLICE_W * NUM_SLICES
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              lt_o,
  output logic              eq_o,
  output logic              gt_o
);

  logic [NUM_SLICES:0] c_lt, c_eq, c_gt;

  // lowest stage starts from a tie
  assign c_lt[0] = VERDICT_EQ.lt;
  assign c_eq[0] = VERDICT_EQ.eq;
  assign c_gt[0] = VERDICT_EQ.gt;

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_stage
    mag_cmp_stage #(.WIDTH(SLICE_W)) u_stage (
      .a_i  (a_i[s*SLICE_W +: SLICE_W]),
      .b_i  (b_i[s*SLICE_W +: SLICE_W]),
      .lt_i (c_lt[s]),
      .eq_i (c_eq[s]),
      .gt_i (c_gt[s]),
      .lt_o (c_lt[s+1]),
      .eq_o (c_eq[s+1]),
      .gt_o (c_gt[s+1])
    );
  end

  assign lt_o = c_lt[NUM_SLICES];
  assign eq_o = c_eq[NUM_SLICES];
  assign gt_o = c_gt[NUM_SLICES];

endmodule

// File: rtl/mag_cmp_chain_chk.sv
module mag_cmp_chain_chk #(
  parameter int unsigned DATA_W  = 12,
  parameter int unsigned SLICE_W = 4
) (
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              lt_o,
  input logic              eq_o,
  input logic              gt_o
);

  localparam int unsigned TOP_LO = DATA_W - SLICE_W;

  logic known;
  assign known = !$isunknown({a_i, b_i, lt_o, eq_o, gt_o});

  always_comb begin
    if (known) begin
      // R1
      gt_match_chk: assert (gt_o == (a_i > b_i));
      // R2
      eq_match_chk: assert (eq_o == (a_i == b_i));
      // R3
      lt_match_chk: assert (lt_o == (a_i < b_i));
      // R4
      one_flag_chk: assert ($countones({lt_o, eq_o, gt_o}) == 1);
      // R5
      top_field_chk: assert ((a_i[DATA_W-1:TOP_LO] == b_i[DATA_W-1:TOP_LO]) ||
                             (gt_o == (a_i[DATA_W-1:TOP_LO] > b_i[DATA_W-1:TOP_LO])));
    end
  end

endmodule

bind mag_cmp_chain mag_cmp_chain_chk #(
  .DATA_W  (DATA_W),
  .SLICE_W (SLICE_W)
) u_chk (
  .a_i  (a_i),
  .b_i  (b_i),
  .lt_o (lt_o),
  .eq_o (eq_o),
  .gt_o (gt_o)
);

// File: tb/mag_cmp_chain_tb_top.sv
module mag_cmp_chain_tb_top;

  localparam int unsigned W = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] a, b;
  logic lt, eq, gt;

  logic [3:0] sa, sb;
  logic s_lti, s_eqi, s_gti, s_lt, s_eq, s_gt;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  mag_cmp_chain dut_i (
    .a_i (a), .b_i (b), .lt_o (lt), .eq_o (eq), .gt_o (gt)
  );

  mag_cmp_stage #(.WIDTH(4)) stg_i (
    .a_i (sa), .b_i (sb),
    .lt_i (s_lti), .eq_i (s_eqi), .gt_i (s_gti),
    .lt_o (s_lt), .eq_o (s_eq), .gt_o (s_gt)
  );

  function automatic logic [2:0] ref_chain(input logic [W-1:0] x, input logic [W-1:0] y);
    return {x < y, x == y, x > y};
  endfunction

  function automatic logic [2:0] ref_stage(input logic [3:0] x, input logic [3:0] y,
                                           input logic [2:0] casc);
    if (x == y) return casc;
    return {x < y, 1'b0, x > y};
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s a=%h b=%h actual{lt,eq,gt}=%b expected=%b", req, a, b, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input string req);
    @(negedge clk);
    a = x; b = y;
    #1;
    check(req, {lt, eq, gt}, ref_chain(x, y));
    // R4 one flag only
    checks++;
    if ($countones({lt, eq, gt}) != 1) begin
      failures++;
      $display("FAIL R4 a=%h b=%h actual=%b expected one-hot", x, y, {lt, eq, gt});
    end
  endtask

  task automatic apply_stage(input logic [3:0] x, input logic [3:0] y,
                             input logic [2:0] casc, input string req);
    @(negedge clk);
    sa = x; sb = y; {s_lti, s_eqi, s_gti} = casc;
    #1;
    check(req, {s_lt, s_eq, s_gt}, ref_stage(x, y, casc));
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] x, y;
    a = '0; b = '0; sa = '0; sb = '0; {s_lti, s_eqi, s_gti} = 3'b010;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R2 idle state: zero operands give equal
    check("R2_reset", {lt, eq, gt}, 3'b010);

    apply(12'h000, 12'h000, "R2");
    apply(12'hFFF, 12'hFFF, "R2");
    apply(12'hFFF, 12'h000, "R1");
    apply(12'h000, 12'hFFF, "R3");
    apply(12'h100, 12'h0FF, "R5");
    apply(12'h0FF, 12'h100, "R5");
    apply(12'h5A0, 12'h59F, "R5");
    apply(12'h7F3, 12'h7F4, "R3");
    apply(12'h7F5, 12'h7F4, "R1");
    apply(12'h800, 12'h7FF, "R1");
    apply(12'h008, 12'h007, "R8");

    for (int i = 0; i < 1500; i++) begin
      x = W'($urandom);
      case (i % 4)
        0: y = W'($urandom);
        1: y = x;
        2: y = x ^ (W'(1) << ($urandom % W));
        default: y = {x[W-1:4], 4'($urandom)};
      endcase
      apply(x, y, (x > y) ? "R1" : (x < y) ? "R3" : "R2");
    end

    // single stage: cascade pass-through and override
    for (int c = 0; c < 8; c++) begin
      apply_stage(4'h6, 4'h6, 3'(c), "R7");
      apply_stage(4'h0, 4'hF, 3'(c), "R6");
      apply_stage(4'h9, 4'h8, 3'(c), "R6");
    end
    apply_stage(4'b1000, 4'b0111, 3'b100, "R8");
    apply_stage(4'b0111, 4'b1000, 3'b001, "R8");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule